// File: doc/BRIEF.md
# Single-Vector Interrupt Sequencer with Shadow Context

This block controls interrupt entry and exit for a small 8-bit processor core. Peripheral request pulses are caught in a pending register. A source may interrupt only when its own enable bit and the global enable are both set. The core marks each instruction boundary. On such a boundary, a qualified request makes the sequencer do four things at once:

- push the current program counter onto a hardware return stack;
- copy the core context into one shadow set (working register, bank select, status, indirect pointer, PC-high latch);
- save the global enable and then clear it;
- steer the fetch unit to the fixed vector address for two instruction cycles, flushing what was fetched.

A return strobe does the reverse. It pops the return address, presents the saved context with a one-cycle restore pulse, and gives the global enable back its value from before entry. The sequencer decodes no instructions and holds no datapath; those stay in the core.

Top module: `irq_sequencer`

## Requirements
- R1: While reset is held and on the first cycle after it:
  - `pc_target_o` reads 0;
  - `gie_o`, `pc_load_o`, `flush_o`, `ctx_restore_o`, `stk_ovf_o`, `stk_unf_o` and every bit of `pend_o` read 0.
- R2: An entry starts on a clock edge only under all of these conditions:
  - `boundary_i` is 1 and `gie_o` is 1;
  - for at least one bit position, `pend_o` and `en_i` are both 1;
  - the sequencer is idle and `retfie_i` is 0.
  In every other case `pc_load_o` stays 0 for that edge.
- R3: Timing of an entry:
  - The cycle after the accepting edge, `pc_load_o` is 1 and `pc_target_o` equals `VEC_ADDR` (default 4).
  - `flush_o` is 1 in that cycle and in the following one, then returns to 0.
  - `boundary_i` and `retfie_i` are ignored during those two cycles.
- R4: The edge that accepts an entry also clears `gie_o`.
- R5: The edge that accepts an entry captures all five context inputs, and the context outputs show them until the next entry. Later changes on the context inputs do not alter them.
- R6: The edge that accepts an entry pushes `pc_i` onto the return stack.
- R7: Timing of a return:
  - A `retfie_i` pulse while idle gives, one cycle later, `pc_load_o`=1 and `ctx_restore_o`=1 together.
  - `pc_target_o` is the most recently pushed address, and `flush_o` is 1 for two cycles.
  - `gie_o` takes the value it had just before the matching entry.
- R8: Return addresses come back in last-in first-out order across nested entries. Nesting happens when `gie_wr_i` sets the enable again inside a handler.
- R9: An entry that finds `STACK_DEPTH` (default 16) addresses already stored does four things:
  - it sets `stk_ovf_o`, which stays set until reset;
  - it still vectors;
  - it discards the pushed address;
  - it leaves the stored addresses poppable in order.
- R10: A return with an empty stack does three things:
  - it sets `stk_unf_o`, which stays set until reset;
  - it loads address 0;
  - it still restores the shadow context.
- R11: Pending bits:
  - A 1 on `req_i[k]` sets `pend_o[k]` on the next edge.
  - The bit stays set through cycles with the global enable clear until a 1 on `clr_i[k]`. A request and a clear in the same cycle leave the bit set.
  - A held pending bit is taken once the enable is set again.
- R12: When `retfie_i` and a qualified entry arrive in the same idle cycle, the return is performed and the entry does not occur.
- R13: While idle, `gie_wr_i`=1 loads `gie_wdata_i` into `gie_o` on the next edge. This holds unless an entry or return is accepted on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Core is at an instruction boundary |
| req_i | input | NUM_SRC | Per-source request pulses |
| clr_i | input | NUM_SRC | Per-source pending clear |
| en_i | input | NUM_SRC | Per-source enable |
| gie_wr_i | input | 1 | Write strobe for the global enable |
| gie_wdata_i | input | 1 | Value written to the global enable |
| retfie_i | input | 1 | Return-from-interrupt strobe |
| pc_i | input | PC_W | Return address of the interrupted flow |
| wreg_i | input | 8 | Working register |
| bank_i | input | 5 | Bank select |
| stat_i | input | 8 | Status register |
| ptr_i | input | 16 | Indirect pointer |
| pchi_i | input | 7 | PC-high latch |
| pend_o | output | NUM_SRC | Pending request bits |
| gie_o | output | 1 | Global interrupt enable |
| pc_load_o | output | 1 | Load `pc_target_o` into the PC |
| pc_target_o | output | PC_W | Vector or return address |
| flush_o | output | 1 | Discard the fetched instruction |
| ctx_restore_o | output | 1 | Copy the shadow context back into the core |
| wreg_o | output | 8 | Shadow working register |
| bank_o | output | 5 | Shadow bank select |
| stat_o | output | 8 | Shadow status |
| ptr_o | output | 16 | Shadow indirect pointer |
| pchi_o | output | 7 | Shadow PC-high latch |
| stk_ovf_o | output | 1 | Sticky stack overflow |
| stk_unf_o | output | 1 | Sticky stack underflow |

## Verification
The assertions take for granted that `req_i`, `en_i`, `boundary_i` and `retfie_i` are settled before each rising edge. They also rely on the core raising `gie_wr_i` only at instruction boundaries. That is what keeps the entry property able to tie a vector load to the enable seen on the previous edge. The stimulus changes all inputs on the falling edge. During the two flush cycles it raises `gie_wr_i` only when a test is aimed at that case, so every load that the properties observe can be traced to one accepting edge.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int WREG_W = 8;
    localparam int BANK_W = 5;
    localparam int STAT_W = 8;
    localparam int PTR_W  = 16;
    localparam int PCHI_W = 7;

    typedef struct packed {
        logic [WREG_W-1:0] wreg;
        logic [BANK_W-1:0] bank;
        logic [STAT_W-1:0] stat;
        logic [PTR_W-1:0]  ptr;
        logic [PCHI_W-1:0] pchi;
    } ctx_t;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LOAD   = 2'd1,
        SEQ_BUBBLE = 2'd2
    } seq_e;

endpackage

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
    parameter int PC_W  = 15,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [PC_W-1:0] din_i,
    output logic [PC_W-1:0] top_o,
    output logic            ovf_o,
    output logic            unf_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] mem;
        logic [CW-1:0]              cnt;
        logic                       ovf;
        logic                       unf;
    } stk_t;

    stk_t s_d, s_q;
    logic [AW-1:0] top_idx;

    assign top_idx = AW'(s_q.cnt - CW'(1));
    assign top_o   = (s_q.cnt == '0) ? '0 : s_q.mem[top_idx];
    assign ovf_o   = s_q.ovf;
    assign unf_o   = s_q.unf;

    always_comb begin
        s_d = s_q;
        if (push_i) begin
            if (s_q.cnt == CW'(DEPTH)) begin
                s_d.ovf = 1'b1;                 // full: address dropped
            end else begin
                s_d.mem[AW'(s_q.cnt)] = din_i;
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end else if (pop_i) begin
            if (s_q.cnt == '0) begin
                s_d.unf = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/irq_shadow.sv
module irq_shadow
    import irq_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic save_i,
    input  ctx_t ctx_i,
    input  logic gie_i,
    output ctx_t ctx_o,
    output logic gie_o
);
    typedef struct packed {
        ctx_t ctx;
        logic gie;
    } shd_t;

    shd_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (save_i) begin
            s_d.ctx = ctx_i;
            s_d.gie = gie_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctx_o = s_q.ctx;
    assign gie_o = s_q.gie;

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
    import irq_seq_pkg::*;
#(
    parameter int          NUM_SRC     = 4,
    parameter int          PC_W        = 15,
    parameter int          STACK_DEPTH = 16,
    parameter int unsigned VEC_ADDR    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary_i,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               gie_wr_i,
    input  logic               gie_wdata_i,
    input  logic               retfie_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [WREG_W-1:0]  wreg_i,
    input  logic [BANK_W-1:0]  bank_i,
    input  logic [STAT_W-1:0]  stat_i,
    input  logic [PTR_W-1:0]   ptr_i,
    input  logic [PCHI_W-1:0]  pchi_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               gie_o,
    output logic               pc_load_o,
    output logic [PC_W-1:0]    pc_target_o,
    output logic               flush_o,
    output logic               ctx_restore_o,
    output logic [WREG_W-1:0]  wreg_o,
    output logic [BANK_W-1:0]  bank_o,
    output logic [STAT_W-1:0]  stat_o,
    output logic [PTR_W-1:0]   ptr_o,
    output logic [PCHI_W-1:0]  pchi_o,
    output logic               stk_ovf_o,
    output logic               stk_unf_o
);
    localparam logic [PC_W-1:0] VEC_PC = PC_W'(VEC_ADDR);

    typedef struct packed {
        seq_e               seq;
        logic [NUM_SRC-1:0] pend;
        logic               gie;
        logic               pc_load;
        logic               flush;
        logic               restore;
        logic [PC_W-1:0]    target;
    } seq_t;

    seq_t s_d, s_q;

    logic            qualified;
    logic            push, pop;
    logic [PC_W-1:0] stk_top;
    logic            shd_gie;
    ctx_t            ctx_in, ctx_saved;

    assign ctx_in = '{wreg: wreg_i, bank: bank_i, stat: stat_i, ptr: ptr_i, pchi: pchi_i};
    assign qualified = boundary_i && s_q.gie && (|(s_q.pend & en_i));

    always_comb begin
        s_d         = s_q;
        s_d.pc_load = 1'b0;
        s_d.restore = 1'b0;
        s_d.pend    = (s_q.pend & ~clr_i) | req_i;
        push        = 1'b0;
        pop         = 1'b0;
        unique case (s_q.seq)
            SEQ_IDLE: begin
                s_d.flush = 1'b0;
                if (retfie_i) begin
                    pop         = 1'b1;
                    s_d.seq     = SEQ_LOAD;
                    s_d.pc_load = 1'b1;
                    s_d.restore = 1'b1;
                    s_d.flush   = 1'b1;
                    s_d.target  = stk_top;
                    s_d.gie     = shd_gie;
                end else if (qualified) begin
                    push        = 1'b1;
                    s_d.seq     = SEQ_LOAD;
                    s_d.pc_load = 1'b1;
                    s_d.flush   = 1'b1;
                    s_d.target  = VEC_PC;
                    s_d.gie     = 1'b0;
                end else if (gie_wr_i) begin
                    s_d.gie = gie_wdata_i;
                end
            end
            SEQ_LOAD: begin
                s_d.seq   = SEQ_BUBBLE;
                s_d.flush = 1'b1;
            end
            SEQ_BUBBLE: begin
                s_d.seq   = SEQ_IDLE;
                s_d.flush = 1'b0;
            end
            default: begin
                s_d.seq   = SEQ_IDLE;
                s_d.flush = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    irq_ret_stack #(
        .PC_W (PC_W),
        .DEPTH(STACK_DEPTH)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push_i(push),
        .pop_i (pop),
        .din_i (pc_i),
        .top_o (stk_top),
        .ovf_o (stk_ovf_o),
        .unf_o (stk_unf_o)
    );

    irq_shadow u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .save_i(push),
        .ctx_i (ctx_in),
        .gie_i (s_q.gie),
        .ctx_o (ctx_saved),
        .gie_o (shd_gie)
    );

    assign pend_o        = s_q.pend;
    assign gie_o         = s_q.gie;
    assign pc_load_o     = s_q.pc_load;
    assign pc_target_o   = s_q.target;
    assign flush_o       = s_q.flush;
    assign ctx_restore_o = s_q.restore;
    assign wreg_o        = ctx_saved.wreg;
    assign bank_o        = ctx_saved.bank;
    assign stat_o        = ctx_saved.stat;
    assign ptr_o         = ctx_saved.ptr;
    assign pchi_o        = ctx_saved.pchi;

endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk #(
    parameter int          NUM_SRC  = 4,
    parameter int          PC_W     = 15,
    parameter int unsigned VEC_ADDR = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               boundary_i,
    input logic [NUM_SRC-1:0] en_i,
    input logic [NUM_SRC-1:0] pend_o,
    input logic               gie_o,
    input logic               pc_load_o,
    input logic [PC_W-1:0]    pc_target_o,
    input logic               flush_o,
    input logic               ctx_restore_o,
    input logic               stk_ovf_o,
    input logic               stk_unf_o
);
    logic entry_load;
    assign entry_load = pc_load_o && !ctx_restore_o;

    assert_entry_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
        entry_load |-> $past(boundary_i && gie_o && (|(pend_o & en_i))));

    assert_vector_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        entry_load |-> (pc_target_o == PC_W'(VEC_ADDR)));

    assert_load_flushes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> flush_o);

    assert_second_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> (flush_o && !pc_load_o));

    assert_entry_gie_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        entry_load |-> !gie_o);

    assert_restore_with_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_restore_o |-> pc_load_o);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf_o |=> stk_ovf_o);

    assert_unf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stk_unf_o |=> stk_unf_o);

endmodule

bind irq_sequencer irq_sequencer_chk #(
    .NUM_SRC (NUM_SRC),
    .PC_W    (PC_W),
    .VEC_ADDR(VEC_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .boundary_i   (boundary_i),
    .en_i         (en_i),
    .pend_o       (pend_o),
    .gie_o        (gie_o),
    .pc_load_o    (pc_load_o),
    .pc_target_o  (pc_target_o),
    .flush_o      (flush_o),
    .ctx_restore_o(ctx_restore_o),
    .stk_ovf_o    (stk_ovf_o),
    .stk_unf_o    (stk_unf_o)
);

// File: tb/irq_sequencer_test.sv
`timescale 1ns/1ps
module irq_sequencer_test;
    localparam int NS = 4;
    localparam int PW = 15;
    localparam int DEPTH = 16;
    localparam int VEC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boundary_i = 1'b0;
    logic [NS-1:0] req_i = '0, clr_i = '0, en_i = '0;
    logic gie_wr_i = 1'b0, gie_wdata_i = 1'b0, retfie_i = 1'b0;
    logic [PW-1:0] pc_i = '0;
    logic [7:0]  wreg_i = '0;
    logic [4:0]  bank_i = '0;
    logic [7:0]  stat_i = '0;
    logic [15:0] ptr_i = '0;
    logic [6:0]  pchi_i = '0;
    logic [NS-1:0] pend_o;
    logic gie_o, pc_load_o, flush_o, ctx_restore_o, stk_ovf_o, stk_unf_o;
    logic [PW-1:0] pc_target_o;
    logic [7:0]  wreg_o;
    logic [4:0]  bank_o;
    logic [7:0]  stat_o;
    logic [15:0] ptr_o;
    logic [6:0]  pchi_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_sequencer #(.NUM_SRC(NS), .PC_W(PW), .STACK_DEPTH(DEPTH), .VEC_ADDR(VEC)) uut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .req_i(req_i), .clr_i(clr_i),
        .en_i(en_i), .gie_wr_i(gie_wr_i), .gie_wdata_i(gie_wdata_i), .retfie_i(retfie_i),
        .pc_i(pc_i), .wreg_i(wreg_i), .bank_i(bank_i), .stat_i(stat_i), .ptr_i(ptr_i),
        .pchi_i(pchi_i), .pend_o(pend_o), .gie_o(gie_o), .pc_load_o(pc_load_o),
        .pc_target_o(pc_target_o), .flush_o(flush_o), .ctx_restore_o(ctx_restore_o),
        .wreg_o(wreg_o), .bank_o(bank_o), .stat_o(stat_o), .ptr_o(ptr_o), .pchi_o(pchi_o),
        .stk_ovf_o(stk_ovf_o), .stk_unf_o(stk_unf_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_gie(input logic g);
        gie_wr_i = 1'b1; gie_wdata_i = g;
        tick();
        gie_wr_i = 1'b0;
    endtask

    function automatic logic [43:0] pack_ctx(input logic [7:0] w, input logic [4:0] b,
                                             input logic [7:0] s, input logic [15:0] p,
                                             input logic [6:0] h);
        return {w, b, s, p, h};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [43:0] saved;
        repeat (3) tick();
        // R1: state under reset
        chk("R1 pc_target", 64'(pc_target_o), 64'd0);
        chk("R1 flags", 64'({gie_o, pc_load_o, flush_o, ctx_restore_o, stk_ovf_o, stk_unf_o, pend_o}), 64'd0);
        rst_n = 1'b1;
        tick();
        chk("R1 after release", 64'({gie_o, pc_load_o, flush_o, stk_ovf_o, stk_unf_o, pc_target_o}), 64'd0);

        // Sweep of global enable x pending x enable: R2 R3 R4 R5 R6 R7 R13
        for (int g = 0; g < 2; g++) begin
            for (int p = 0; p < (1 << NS); p++) begin
                for (int e = 0; e < (1 << NS); e++) begin
                    automatic int k = g * 256 + p * 16 + e;
                    automatic logic take = (g == 1) && ((p & e) != 0);
                    clr_i = '1; tick(); clr_i = '0;
                    req_i = NS'(p); en_i = NS'(e);
                    gie_wr_i = 1'b1; gie_wdata_i = 1'(g);
                    tick();
                    req_i = '0; gie_wr_i = 1'b0;
                    chk("R11 pending latched", 64'(pend_o), 64'(p));
                    chk("R13 gie written", 64'(gie_o), 64'(g));
                    pc_i   = PW'(k * 3 + 17);
                    wreg_i = 8'(k); bank_i = 5'(k ^ 5); stat_i = 8'(k * 7);
                    ptr_i  = 16'(k * 257); pchi_i = 7'(k + 3);
                    saved  = pack_ctx(wreg_i, bank_i, stat_i, ptr_i, pchi_i);
                    boundary_i = 1'b1;
                    tick();
                    boundary_i = 1'b0;
                    chk("R2 qualify", 64'(pc_load_o), 64'(take));
                    if (take) begin
                        chk("R3 vector", 64'(pc_target_o), 64'(VEC));
                        chk("R3 flush1", 64'(flush_o), 64'd1);
                        chk("R4 gie cleared", 64'(gie_o), 64'd0);
                        wreg_i = ~wreg_i; ptr_i = ~ptr_i; stat_i = ~stat_i;
                        bank_i = ~bank_i; pchi_i = ~pchi_i;
                        boundary_i = 1'b1;  // ignored while sequencing
                        tick();
                        boundary_i = 1'b0;
                        chk("R3 flush2", 64'({flush_o, pc_load_o}), 64'b10);
                        tick();
                        chk("R3 flush end", 64'(flush_o), 64'd0);
                        chk("R5 shadow", 64'({wreg_o, bank_o, stat_o, ptr_o, pchi_o}), 64'(saved));
                        retfie_i = 1'b1;
                        tick();
                        retfie_i = 1'b0;
                        chk("R7 restore", 64'({pc_load_o, ctx_restore_o, flush_o}), 64'b111);
                        chk("R6 R7 return addr", 64'(pc_target_o), 64'(k * 3 + 17));
                        chk("R7 gie back", 64'(gie_o), 64'd1);
                        tick(); tick();
                    end else begin
                        chk("R2 gie kept", 64'(gie_o), 64'(g));
                    end
                end
            end
        end
        chk("R9 R10 no stack fault in sweep", 64'({stk_ovf_o, stk_unf_o}), 64'd0);

        // R11: pending held while disabled, taken after enable; request+clear same cycle
        clr_i = '1; tick(); clr_i = '0;
        write_gie(1'b0);
        en_i = 4'b0100; req_i = 4'b0100; tick(); req_i = '0;
        boundary_i = 1'b1; tick(); boundary_i = 1'b0;
        chk("R11 held no take", 64'({pc_load_o, pend_o}), 64'({1'b0, 4'b0100}));
        req_i = 4'b0100; clr_i = 4'b0100; tick(); req_i = '0; clr_i = '0;
        chk("R11 req wins clr", 64'(pend_o), 64'b0100);
        write_gie(1'b1);
        pc_i = PW'(15'h2AB);
        boundary_i = 1'b1; tick(); boundary_i = 1'b0;
        chk("R11 taken later", 64'({pc_load_o, pc_target_o}), 64'({1'b1, PW'(VEC)}));
        tick(); tick();

        // R12: return beats simultaneous qualified entry
        write_gie(1'b1);
        pc_i = PW'(15'h111);
        retfie_i = 1'b1; boundary_i = 1'b1;
        tick();
        retfie_i = 1'b0; boundary_i = 1'b0;
        chk("R12 return wins", 64'({ctx_restore_o, pc_target_o}), 64'({1'b1, PW'(15'h2AB)}));
        tick(); tick();

        // R8 R9: nest DEPTH+1 entries by re-enabling inside the handler
        for (int n = 0; n <= DEPTH; n++) begin
            write_gie(1'b1);
            pc_i = PW'(1000 + n);
            boundary_i = 1'b1; tick(); boundary_i = 1'b0;
            chk("R8 nested vector", 64'({pc_load_o, pc_target_o}), 64'({1'b1, PW'(VEC)}));
            tick(); tick();
            if (n == DEPTH - 1) chk("R9 full no ovf yet", 64'(stk_ovf_o), 64'd0);
        end
        chk("R9 overflow set", 64'(stk_ovf_o), 64'd1);
        for (int n = DEPTH - 1; n >= 0; n--) begin
            retfie_i = 1'b1; tick(); retfie_i = 1'b0;
            chk("R8 LIFO pop", 64'(pc_target_o), 64'(1000 + n));
            tick(); tick();
        end
        chk("R10 no underflow yet", 64'(stk_unf_o), 64'd0);
        retfie_i = 1'b1; tick(); retfie_i = 1'b0;
        chk("R10 empty pop", 64'({ctx_restore_o, pc_target_o}), 64'({1'b1, PW'(0)}));
        tick();
        chk("R10 underflow set", 64'({stk_unf_o, stk_ovf_o}), 64'b11);
        tick(); tick();
        chk("R10 sticky", 64'(stk_unf_o), 64'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule